// File: doc/BRIEF.md
# Multi-Channel Service Request Scheduler

This block decides which of sixteen timer channels is handed to a single shared execution engine next. Each channel can ask for service for four separate causes (a host request, a link from another channel, a match event and a capture event). Every cause is latched as a sticky pending bit for its channel. A host-written 2-bit code per channel either disables the channel or gives it one of three priority levels.

When the engine signals that it is ready and no service is under way, the scheduler picks a winner. It takes the highest level that has any pending, enabled channel, and within that level the lowest-numbered channel. It then emits a one-cycle grant strobe together with the channel number and the reasons it latched for that channel. The number and reasons stay on the outputs until the next grant. When the engine pulses done, the serviced reasons are cleared. Reasons that arrived during the service stay pending, so the channel is granted again later.

Top module: `svc_sched`

## Requirements
- R1: After reset, `grant_valid` is 0, `grant_chan` is 0, `grant_why` is 0, and no channel holds a pending reason.
- R2: Channel c's causes arrive on `req_in[4c+3:4c]`, with bit 0 = host, bit 1 = link, bit 2 = match and bit 3 = capture. Each bit is latched sticky. At a grant, `grant_why` carries the winner's latched bits in the same bit order and is never zero.
- R3: Channel c's level is `prio_in[2c+1:2c]`: 00 = disabled, 01 = low, 10 = middle, 11 = high. A disabled channel is never granted, and requests that arrive while it is disabled are dropped rather than latched.
- R4: Among eligible channels (enabled, with at least one pending reason), one at a strictly higher level always wins over one at a lower level.
- R5: Among eligible channels at the winning level, the lowest-numbered one is granted.
- R6: A grant is issued only in the cycle after `eng_ready` is sampled high while no service is in progress. `grant_valid` is then high for exactly one cycle.
- R7: `grant_chan` and `grant_why` stay unchanged in every cycle without a grant.
- R8: From a grant until the matching `eng_done` is sampled, no further grant is issued, even when `eng_ready` is high and other channels are pending.
- R9: An `eng_done` during service clears exactly the granted reasons of the granted channel. Other reasons and other channels are unaffected.
- R10: A reason that arrives for the channel under service, at the grant cycle or later, stays pending after `eng_done`.
- R11: `eng_done` while no service is in progress has no effect.
- R12: `eng_ready` with no eligible channel produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_in | input | 64 | Per-channel request causes, 4 bits per channel |
| prio_in | input | 32 | Per-channel priority code, 2 bits per channel |
| eng_ready | input | 1 | Engine can accept a new channel |
| eng_done | input | 1 | Engine finished the granted channel |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_chan | output | 4 | Granted channel number |
| grant_why | output | 4 | Reasons latched for the granted channel |

## Verification
Every ordered pair of channels is given every combination of the three enabled levels, and both channels raise requests together. The first grant then separates the level-first rule (unequal levels) from the lowest-number rule (equal levels), and the second grant shows that the loser is still pending. Random sweeps that set all sixteen priority codes and sparse request patterns at once are drained grant by grant against an arithmetic model, which exposes any wrong ordering among many contenders. Directed sequences raise requests during service, pulse done while idle, toggle a channel between disabled and enabled, and assert ready while busy. These tell apart the sticky-reason, masking and one-at-a-time rules.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;
    localparam int NSRC = 4;
    localparam int PW   = 2;

    localparam int RSN_HOST    = 0;
    localparam int RSN_LINK    = 1;
    localparam int RSN_MATCH   = 2;
    localparam int RSN_CAPTURE = 3;

    typedef enum logic [PW-1:0] {
        LVL_OFF  = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_MID  = 2'b10,
        LVL_HIGH = 2'b11
    } lvl_e;

    localparam int NLVL = (1 << PW) - 1;
endpackage

// File: rtl/svc_sched_pend.sv
module svc_sched_pend
    import svc_sched_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*NSRC-1:0]    req_in,
    input  logic [NCH*PW-1:0]      prio_in,
    input  logic                   clr_en,
    input  logic [CH_W-1:0]        clr_ch,
    input  logic [NSRC-1:0]        clr_mask,
    output logic [NCH*NSRC-1:0]    pend_o,
    output logic [NCH*NSRC-1:0]    req_ok_o
);
    typedef struct packed {
        logic [NCH-1:0][NSRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [NCH-1:0][NSRC-1:0] req_ok;

    // Requests of disabled channels are dropped before latching.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_gate
            assign req_ok[c] = (prio_in[c*PW +: PW] == LVL_OFF) ? '0
                                                                  : req_in[c*NSRC +: NSRC];
            assign pend_o[c*NSRC +: NSRC]   = st_q.pend[c];
            assign req_ok_o[c*NSRC +: NSRC] = req_ok[c];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (clr_en && (clr_ch == CH_W'(c))) begin
                st_d.pend[c] = st_d.pend[c] & ~clr_mask;
            end
            // A cause arriving in the clear cycle wins over the clear.
            st_d.pend[c] = st_d.pend[c] | req_ok[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            // R3: a disabled channel gains no new pending bits
            p_off_no_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (prio_in[c*PW +: PW] == LVL_OFF)
                |=> ((st_q.pend[c] & ~$past(st_q.pend[c])) == '0));
            // R9: served bits are gone unless re-raised that cycle
            p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en && (clr_ch == CH_W'(c)) && (req_ok[c] == '0))
                |=> ((st_q.pend[c] & $past(clr_mask)) == '0));
            // R2: with no clear, pending bits never drop
            p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !(clr_en && (clr_ch == CH_W'(c)))
                |=> ((~st_q.pend[c] & $past(st_q.pend[c])) == '0));
        end
    endgenerate
endmodule

// File: rtl/svc_sched_arb.sv
module svc_sched_arb
    import svc_sched_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*NSRC-1:0] pend_in,
    input  logic [NCH*PW-1:0]   prio_in,
    output logic                win_vld,
    output logic [CH_W-1:0]     win_ch,
    output logic [NSRC-1:0]     win_why
);
    logic [NLVL-1:0][NCH-1:0]  elig;
    logic [NLVL-1:0]           lvl_any;
    logic [NLVL-1:0][CH_W-1:0] lvl_ch;

    // One lowest-index finder per level, all working in parallel.
    generate
        for (genvar l = 0; l < NLVL; l++) begin : g_lvl
            for (genvar c = 0; c < NCH; c++) begin : g_ch
                assign elig[l][c] = (pend_in[c*NSRC +: NSRC] != '0)
                                 && (prio_in[c*PW +: PW] == PW'(l + 1));
            end
            assign lvl_any[l] = |elig[l];
            always_comb begin
                lvl_ch[l] = '0;
                for (int c = NCH - 1; c >= 0; c--) begin
                    if (elig[l][c]) begin
                        lvl_ch[l] = CH_W'(c);
                    end
                end
            end
        end
    endgenerate

    // Highest non-empty level selects its finder.
    always_comb begin
        win_vld = 1'b0;
        win_ch  = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_any[l]) begin
                win_vld = 1'b1;
                win_ch  = lvl_ch[l];
            end
        end
    end

    always_comb begin
        win_why = '0;
        for (int c = 0; c < NCH; c++) begin
            if (win_ch == CH_W'(c)) begin
                win_why = pend_in[c*NSRC +: NSRC];
            end
        end
    end

    // R3: a winner is always enabled
    p_win_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (prio_in[win_ch*PW +: PW] != LVL_OFF));
    // R2: a winner always has a latched reason
    p_win_reason_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> (win_why != '0));
endmodule

// File: rtl/svc_sched.sv
module svc_sched
    import svc_sched_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*NSRC-1:0] req_in,
    input  logic [NCH*PW-1:0]   prio_in,
    input  logic                eng_ready,
    input  logic                eng_done,
    output logic                grant_valid,
    output logic [CH_W-1:0]     grant_chan,
    output logic [NSRC-1:0]     grant_why
);
    typedef struct packed {
        logic            busy;
        logic            gv;
        logic [CH_W-1:0] gch;
        logic [NSRC-1:0] gwhy;
        logic [NSRC-1:0] rearm;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [NCH*NSRC-1:0] pend;
    logic [NCH*NSRC-1:0] req_ok;
    logic                win_vld;
    logic [CH_W-1:0]     win_ch;
    logic [NSRC-1:0]     win_why;
    logic                clr_en;
    logic [NSRC-1:0]     clr_mask;
    logic [NSRC-1:0]     req_srv;
    logic [NSRC-1:0]     req_win;

    svc_sched_pend #(.NCH(NCH), .CH_W(CH_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .prio_in  (prio_in),
        .clr_en   (clr_en),
        .clr_ch   (st_q.gch),
        .clr_mask (clr_mask),
        .pend_o   (pend),
        .req_ok_o (req_ok)
    );

    svc_sched_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_in (pend),
        .prio_in (prio_in),
        .win_vld (win_vld),
        .win_ch  (win_ch),
        .win_why (win_why)
    );

    // Causes arriving now for the served channel and for the winner.
    always_comb begin
        req_srv = '0;
        req_win = '0;
        for (int c = 0; c < NCH; c++) begin
            if (st_q.gch == CH_W'(c)) req_srv = req_ok[c*NSRC +: NSRC];
            if (win_ch == CH_W'(c))   req_win = req_ok[c*NSRC +: NSRC];
        end
    end

    assign clr_mask = st_q.gwhy & ~st_q.rearm;

    always_comb begin
        st_d    = st_q;
        st_d.gv = 1'b0;
        clr_en  = 1'b0;
        if (st_q.busy) begin
            st_d.rearm = st_q.rearm | req_srv;
            if (eng_done) begin
                st_d.busy = 1'b0;
                clr_en    = 1'b1;
            end
        end else if (eng_ready && win_vld) begin
            st_d.busy  = 1'b1;
            st_d.gv    = 1'b1;
            st_d.gch   = win_ch;
            st_d.gwhy  = win_why;
            st_d.rearm = req_win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid = st_q.gv;
    assign grant_chan  = st_q.gch;
    assign grant_why   = st_q.gwhy;

    // R6: the strobe lasts one cycle
    p_strobe_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);
    // R6: a grant follows a sampled ready
    p_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(eng_ready));
    // R7: outputs hold between grants
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> ($stable(grant_chan) && $stable(grant_why)));
    // R8: no grant while a service is open
    p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done) |=> !grant_valid);
endmodule

// File: tb/svc_sched_tb.sv
module svc_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req_in = '0;
    logic [31:0] prio_in = '0;
    logic        eng_ready = 1'b0;
    logic        eng_done = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_chan;
    logic [3:0]  grant_why;

    int errs = 0;
    int checks = 0;
    bit ended = 1'b0;

    logic [3:0] mp [16];
    logic       mbusy = 1'b0;
    logic [3:0] mch = '0;
    logic [3:0] mwhy = '0;
    logic [3:0] marr = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    svc_sched u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_in      (req_in),
        .prio_in     (prio_in),
        .eng_ready   (eng_ready),
        .eng_done    (eng_done),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan),
        .grant_why   (grant_why)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    task automatic set_prio(input int c, input logic [1:0] p);
        prio_in[c*2 +: 2] = p;
    endtask

    task automatic pulse_req(input logic [63:0] v);
        req_in = v;
        for (int c = 0; c < 16; c++) begin
            if (prio_in[c*2 +: 2] != 2'b00) begin
                mp[c] = mp[c] | v[c*4 +: 4];
                if (mbusy && mch == 4'(c)) marr = marr | v[c*4 +: 4];
            end
        end
        @(negedge clk);
        req_in = '0;
    endtask

    task automatic try_grant(input string tag, output bit got);
        bit found = 1'b0;
        int ech = 0;
        logic [3:0] hc, hw;
        if (!mbusy) begin
            for (int lv = 3; lv >= 1; lv--) begin
                for (int c = 0; c < 16; c++) begin
                    if (!found && prio_in[c*2 +: 2] == 2'(lv) && mp[c] != 4'd0) begin
                        found = 1'b1;
                        ech = c;
                    end
                end
            end
        end
        eng_ready = 1'b1;
        @(negedge clk);
        eng_ready = 1'b0;
        chk(grant_valid == found, {tag, " valid"}, int'(grant_valid), int'(found));
        if (found) begin
            chk(grant_chan == 4'(ech), {tag, " chan"}, int'(grant_chan), ech);
            chk(grant_why == mp[ech], {tag, " R2 why"}, int'(grant_why), int'(mp[ech]));
            mbusy = 1'b1;
            mch = 4'(ech);
            mwhy = mp[ech];
            marr = 4'd0;
        end
        hc = grant_chan;
        hw = grant_why;
        @(negedge clk);
        chk(grant_valid == 1'b0, "R6 strobe length", int'(grant_valid), 0);
        chk(grant_chan == hc && grant_why == hw, "R7 hold", int'({grant_chan, grant_why}),
            int'({hc, hw}));
        got = found;
    endtask

    task automatic finish_svc();
        eng_done = 1'b1;
        if (mbusy) begin
            mp[mch] = mp[mch] & ~(mwhy & ~marr);
            mbusy = 1'b0;
        end
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic drain(input string tag);
        bit got;
        for (int k = 0; k < 40; k++) begin
            try_grant(tag, got);
            if (!got) break;
            finish_svc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        bit got;
        for (int c = 0; c < 16; c++) mp[c] = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(grant_valid == 1'b0 && grant_chan == 4'd0 && grant_why == 4'd0, "R1 reset",
            int'({grant_valid, grant_chan, grant_why}), 0);

        // R12 ready with every channel enabled but nothing pending
        for (int c = 0; c < 16; c++) set_prio(c, 2'b01);
        try_grant("R12 empty", got);

        // R6 pending but no ready: nothing granted
        pulse_req(64'h5 << (3*4));
        repeat (3) begin
            @(negedge clk);
            chk(grant_valid == 1'b0, "R6 no ready", int'(grant_valid), 0);
        end
        // R2 reason bits host+match reported
        try_grant("R2 reasons", got);
        chk(grant_why == 4'b0101, "R2 bit order", int'(grant_why), 5);
        finish_svc();

        // R3 disabled channel drops requests
        set_prio(7, 2'b00);
        pulse_req(64'hF << (7*4));
        try_grant("R3 disabled", got);
        set_prio(7, 2'b11);
        try_grant("R3 dropped", got);
        chk(got == 1'b0, "R3 not latched", int'(got), 0);

        // R8 ready while busy, R11 done while idle
        pulse_req((64'h1 << (2*4)) | (64'h8 << (9*4)));
        try_grant("R8 first", got);
        pulse_req(64'h2 << (4*4));
        try_grant("R8 busy", got);
        chk(got == 1'b0, "R8 no second grant", int'(got), 0);
        finish_svc();
        finish_svc();
        drain("R11 after idle done");

        // R10 same reason re-raised during service stays pending
        pulse_req(64'h1 << (2*4));
        try_grant("R10 grant", got);
        pulse_req(64'h3 << (2*4));
        finish_svc();
        try_grant("R10 again", got);
        chk(grant_why == 4'b0011, "R10 kept reasons", int'(grant_why), 3);
        finish_svc();

        // R9 only served reasons cleared
        pulse_req((64'h6 << (5*4)) | (64'h4 << (6*4)));
        try_grant("R9 grant", got);
        pulse_req(64'h1 << (5*4));
        finish_svc();
        try_grant("R9 residual", got);
        chk(grant_chan == 4'd5 && grant_why == 4'b0001, "R9 residual reason",
            int'({grant_chan, grant_why}), int'({4'd5, 4'd1}));
        finish_svc();
        drain("R9 others intact");

        // R4 R5 pair sweep at every level combination
        for (int i = 0; i < 16; i++) begin
            for (int j = i + 1; j < 16; j++) begin
                for (int pi = 1; pi <= 3; pi++) begin
                    for (int pj = 1; pj <= 3; pj++) begin
                        prio_in = '0;
                        set_prio(i, 2'(pi));
                        set_prio(j, 2'(pj));
                        pulse_req((64'(rnd() % 15 + 1) << (i*4)) |
                                  (64'(rnd() % 15 + 1) << (j*4)));
                        drain(pi == pj ? "R5 equal level" : "R4 level order");
                    end
                end
            end
        end

        // R4 R5 random crowds
        for (int n = 0; n < 80; n++) begin
            for (int c = 0; c < 16; c++) set_prio(c, 2'(rnd() >> 7));
            pulse_req({rnd(), rnd()} & {rnd(), rnd()});
            drain("R4 R5 crowd");
        end

        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule